// File: doc/BRIEF.md
# Core standby clock-gating controller

This controller sits beside one processor core and owns the single enable at the root of that core's clock tree. When the core signals a wait-for-interrupt or wait-for-event instruction, the controller keeps the clock running until the pipeline reports that every in-flight instruction has retired and the memory side reports that earlier accesses and stores are drained. It then shuts the clock off. The core keeps its power and its state.

While the core is in standby, three service sources can ask for the clock back briefly without waking the core: data-cache snoops, cache/TLB maintenance and debug/trace register accesses. Each source uses a request/grant handshake. The source raises `svc_req[i]` and holds it. The controller grants one source at a time on `svc_ack`, giving the lowest index priority. The granted source keeps its request high until it pulses `svc_done[i]`, and it drops the request in that same cycle. A source that is not granted must keep waiting; it is never dropped.

Standby ends according to the instruction that entered it. A wait-for-interrupt ends only on `irq_wake`. A wait-for-event ends on the external `evt_in` or on `wfe_wake`. The exit passes through one wake cycle that pulses `wake_done`. A one-bit event flag lets a wait-for-event fall through at once if an event was already signalled. Each core has its own instance, and the instances share no state.

Top module: `core_standby_ctrl`

## Requirements
- R1: After asynchronous reset the block is in run: `core_clk_en`=1, `in_standby`=0, `svc_ack`=0, `wake_done`=0, and the event flag is clear, so the first `wfe_req` goes on to standby.
- R2: In run, a `wfi_req` or `wfe_req` pulse starts draining (`wfi_req` wins if both are present). `core_clk_en` stays 1 as long as either `pipe_idle` or `mem_drained` is low. On the clock edge that sees both high, the block enters standby, and from that edge `core_clk_en`=0 and `in_standby`=1.
- R3: `core_clk` gives a rising edge for every `clk` rising edge while the enable is held, and gives none while the block is in gated standby. The enable passes through a latch that is open only while `clk` is low.
- R4: In gated standby, a nonzero `svc_req` moves the block into service on the next edge. In service, `svc_ack` is one-hot on the lowest requesting index, `core_clk_en`=1 and `in_standby` stays 1. The grant holds until that source pulses `svc_done`, and the block then returns to gated standby on that edge.
- R5: Standby entered by `wfi_req` ends only on `irq_wake`. `evt_in` and `wfe_wake` leave it unchanged.
- R6: Standby entered by `wfe_req` ends only on `evt_in` or `wfe_wake`. `irq_wake` leaves it unchanged.
- R7: A wake moves the block to a wake cycle with `wake_done`=1, `core_clk_en`=1 and `in_standby`=0. The block is back in run on the next edge with `wake_done`=0.
- R8: A wake condition that arrives during service is held. When `svc_done` ends the service, the block goes to the wake cycle and not back to standby.
- R9: If a wake condition and a service request arrive in the same cycle in gated standby, the wake wins: the next cycle is the wake cycle and `svc_ack` stays 0.
- R10: The event flag is set by `evt_in` or `sev_pulse` while the block is in run. A `wfe_req` made while the flag is set clears the flag and the block stays in run. The next `wfe_req` then drains and enters standby.
- R11: A wake condition that matches the pending instruction and arrives during draining cancels the standby entry and goes straight to the wake cycle.
- R12: `wfi_req` and `wfe_req` have no effect outside run. In particular, the wake rule chosen on entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock ahead of the gate |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req | input | 1 | Pulse: core executed wait-for-interrupt |
| wfe_req | input | 1 | Pulse: core executed wait-for-event |
| pipe_idle | input | 1 | All in-flight instructions have retired |
| mem_drained | input | 1 | Earlier memory accesses are complete and stores are issued |
| irq_wake | input | 1 | Wake-up interrupt |
| evt_in | input | 1 | External event input |
| sev_pulse | input | 1 | Local send-event pulse |
| wfe_wake | input | 1 | Other wait-for-event wake-up condition |
| svc_req | input | NUM_SRC | Service requests (0 snoop, 1 maintenance, 2 debug access), held until done |
| svc_done | input | NUM_SRC | Pulse from the granted source when its service is finished |
| core_clk_en | output | 1 | Registered clock enable for the core clock root |
| core_clk | output | 1 | Gated core clock |
| in_standby | output | 1 | The core is in standby, including during service |
| svc_ack | output | NUM_SRC | One-hot grant to the serviced source |
| wake_done | output | 1 | One-cycle pulse on leaving standby |

## Verification
Two functions can land in the same cycle: a wake condition and the start or end of a service. The bench provokes both cases. It asserts `irq_wake` together with a new `svc_req` in gated standby, and it pulses `irq_wake` in the middle of a service before the source's done pulse. In the first case the bench expects the wake cycle with no grant. In the second it expects the grant to hold through the wake and the wake cycle to follow the done pulse directly, with no return to gated standby. The service sweep also covers every combination of the three sources requesting together and checks that grants are given in order of index.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_STANDBY = 3'd2,
    ST_SERVICE = 3'd3,
    ST_WAKE    = 3'd4
  } stby_state_e;
endpackage

// File: rtl/stby_event_flag.sv
module stby_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic evt_in,
  input  logic sev_pulse,
  input  logic consume,
  output logic flag
);
  logic set_now;
  assign set_now = in_run && (evt_in || sev_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_now || (flag && !consume);
  end

  AST_EV_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !set_now) |=> !flag); // R10
  AST_EV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> flag); // R10
endmodule

// File: rtl/stby_svc_arb.sv
module stby_svc_arb #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] done,
  input  logic               start,
  output logic [NUM_SRC-1:0] grant,
  output logic               any_req,
  output logic               fin
);
  logic [NUM_SRC-1:0] lowest;

  assign any_req = |req;
  assign lowest  = req & (~req + NUM_SRC'(1));
  assign fin     = |(done & grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     grant <= '0;
    else if (start) grant <= lowest;
    else if (fin)   grant <= '0;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !fin && !start) |=> $stable(grant)); // R4
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wfi_req,
  input  logic        wfe_req,
  input  logic        ev_flag,
  input  logic        pipe_idle,
  input  logic        mem_drained,
  input  logic        irq_wake,
  input  logic        evt_in,
  input  logic        wfe_wake,
  input  logic        svc_any,
  input  logic        svc_fin,
  output stby_state_e state,
  output stby_state_e state_nx,
  output logic        svc_start,
  output logic        ev_consume
);
  logic mode_wfe, mode_wfe_nx;
  logic wake_pend, wake_pend_nx;
  logic wake_now;

  assign wake_now = mode_wfe ? (evt_in || wfe_wake) : irq_wake;

  always_comb begin
    state_nx     = state;
    mode_wfe_nx  = mode_wfe;
    wake_pend_nx = wake_pend;
    svc_start    = 1'b0;
    ev_consume   = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (wfi_req) begin
          state_nx    = ST_DRAIN;
          mode_wfe_nx = 1'b0;
        end else if (wfe_req) begin
          if (ev_flag) begin
            ev_consume = 1'b1;
          end else begin
            state_nx    = ST_DRAIN;
            mode_wfe_nx = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (wake_now)                      state_nx = ST_WAKE;
        else if (pipe_idle && mem_drained) state_nx = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (wake_now) begin
          state_nx = ST_WAKE;
        end else if (svc_any) begin
          state_nx  = ST_SERVICE;
          svc_start = 1'b1;
        end
      end
      ST_SERVICE: begin
        wake_pend_nx = wake_pend || wake_now;
        if (svc_fin) begin
          state_nx     = (wake_pend || wake_now) ? ST_WAKE : ST_STANDBY;
          wake_pend_nx = 1'b0;
        end
      end
      ST_WAKE: begin
        state_nx     = ST_RUN;
        wake_pend_nx = 1'b0;
      end
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      mode_wfe  <= 1'b0;
      wake_pend <= 1'b0;
    end else begin
      state     <= state_nx;
      mode_wfe  <= mode_wfe_nx;
      wake_pend <= wake_pend_nx;
    end
  end

  AST_DRAIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !(pipe_idle && mem_drained)) |=> state != ST_STANDBY); // R2
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |=> (state == ST_RUN)); // R7
  AST_CONSUME_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_consume |=> (state == ST_RUN)); // R10
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |=> $stable(mode_wfe)); // R12
endmodule

// File: rtl/stby_clk_gate.sv
module stby_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_nx,
  output logic en_q,
  output logic gclk
);
  logic en_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_nx;
  end

  always_latch begin
    if (!clk) en_lat = en_q;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/core_standby_ctrl.sv
module core_standby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_req,
  input  logic               wfe_req,
  input  logic               pipe_idle,
  input  logic               mem_drained,
  input  logic               irq_wake,
  input  logic               evt_in,
  input  logic               sev_pulse,
  input  logic               wfe_wake,
  input  logic [NUM_SRC-1:0] svc_req,
  input  logic [NUM_SRC-1:0] svc_done,
  output logic               core_clk_en,
  output logic               core_clk,
  output logic               in_standby,
  output logic [NUM_SRC-1:0] svc_ack,
  output logic               wake_done
);
  stby_state_e state, state_nx;
  logic ev_flag, ev_consume, svc_start, svc_any, svc_fin;

  stby_event_flag u_evt (
    .clk(clk), .rst_n(rst_n), .in_run(state == ST_RUN), .evt_in(evt_in),
    .sev_pulse(sev_pulse), .consume(ev_consume), .flag(ev_flag)
  );

  stby_svc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(svc_req), .done(svc_done),
    .start(svc_start), .grant(svc_ack), .any_req(svc_any), .fin(svc_fin)
  );

  stby_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .ev_flag(ev_flag), .pipe_idle(pipe_idle), .mem_drained(mem_drained),
    .irq_wake(irq_wake), .evt_in(evt_in), .wfe_wake(wfe_wake),
    .svc_any(svc_any), .svc_fin(svc_fin), .state(state), .state_nx(state_nx),
    .svc_start(svc_start), .ev_consume(ev_consume)
  );

  stby_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en_nx(state_nx != ST_STANDBY),
    .en_q(core_clk_en), .gclk(core_clk)
  );

  assign in_standby = (state == ST_STANDBY) || (state == ST_SERVICE);
  assign wake_done  = (state == ST_WAKE);

  AST_GATED_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STANDBY) |-> !core_clk_en); // R3
  AST_CLOCK_FOR_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack != '0) |-> (core_clk_en && in_standby)); // R4
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done); // R7
  AST_NO_GRANT_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (svc_ack == '0)); // R9
endmodule

// File: tb/test_core_standby_ctrl.sv
`timescale 1ns/1ps
module test_core_standby_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, pipe_idle = 0, mem_drained = 0;
  logic irq_wake = 0, evt_in = 0, sev_pulse = 0, wfe_wake = 0;
  logic [2:0] svc_req = '0, svc_done = '0;
  logic core_clk_en, core_clk, in_standby, wake_done;
  logic [2:0] svc_ack;
  int checks = 0, errors = 0, gcnt = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge core_clk) gcnt++;

  core_standby_ctrl #(.NUM_SRC(3)) i_core_standby_ctrl (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .pipe_idle(pipe_idle), .mem_drained(mem_drained), .irq_wake(irq_wake),
    .evt_in(evt_in), .sev_pulse(sev_pulse), .wfe_wake(wfe_wake),
    .svc_req(svc_req), .svc_done(svc_done), .core_clk_en(core_clk_en),
    .core_clk(core_clk), .in_standby(in_standby), .svc_ack(svc_ack),
    .wake_done(wake_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_st(string req, int en, int st, int wd, int ack);
    chk({req, " core_clk_en"}, core_clk_en, en);
    chk({req, " in_standby"}, in_standby, st);
    chk({req, " wake_done"}, wake_done, wd);
    chk({req, " svc_ack"}, svc_ack, ack);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wfi_req = 0; wfe_req = 0; irq_wake = 0; evt_in = 0;
    sev_pulse = 0; wfe_wake = 0; svc_done = '0;
  endtask

  task automatic enter_standby(bit wfe);
    pipe_idle = 1; mem_drained = 1;
    wfi_req = !wfe; wfe_req = wfe;
    tick();
    tick();
    chk_st("R2 standby entry", 0, 1, 0, 0);
  endtask

  task automatic wake_out(bit wfe);
    if (wfe) evt_in = 1; else irq_wake = 1;
    tick();
    chk_st("R7 wake cycle", 1, 0, 1, 0);
    tick();
    chk_st("R7 back in run", 1, 0, 0, 0);
  endtask

  initial begin
    int g0;
    int rem, g;
    bit expw;
    @(negedge clk);
    @(negedge clk);
    chk_st("R1 reset", 1, 0, 0, 0);
    rst_n = 1;
    tick();
    chk_st("R1 after release", 1, 0, 0, 0);
    g0 = gcnt; tick(); tick();
    chk("R3 clock runs in run", gcnt - g0, 2);
    // R1: event flag clear after reset, so WFE goes to standby
    enter_standby(1'b1);
    wake_out(1'b1);

    // Sweep: mode x wake source x drain wait (R2 R3 R5 R6 R7)
    for (int m = 0; m < 2; m++) begin
      for (int wk = 0; wk < 3; wk++) begin
        for (int d = 0; d < 3; d++) begin
          pipe_idle = 0; mem_drained = 0;
          wfi_req = (m == 0); wfe_req = (m == 1);
          tick();
          chk_st("R2 draining", 1, 0, 0, 0);
          for (int i = 0; i < d; i++) begin
            pipe_idle = (i % 2 == 0); mem_drained = (i % 2 != 0);
            tick();
            chk_st("R2 partial drain holds clock", 1, 0, 0, 0);
          end
          pipe_idle = 1; mem_drained = 1;
          tick();
          chk_st("R2 drained", 0, 1, 0, 0);
          g0 = gcnt; tick(); tick();
          chk("R3 no gated edges", gcnt - g0, 0);
          irq_wake = (wk == 0); evt_in = (wk == 1); wfe_wake = (wk == 2);
          expw = (m == 0) ? (wk == 0) : (wk != 0);
          tick();
          if (expw) begin
            chk_st(m == 0 ? "R5 wfi wake" : "R6 wfe wake", 1, 0, 1, 0);
            tick();
            chk_st("R7 run", 1, 0, 0, 0);
          end else begin
            chk_st(m == 0 ? "R5 wfi ignores event" : "R6 wfe ignores irq", 0, 1, 0, 0);
            wake_out(m[0]);
          end
        end
      end
    end

    // R4: every request combination, granted in index order
    for (int mask = 1; mask < 8; mask++) begin
      enter_standby(1'b0);
      rem = mask;
      while (rem != 0) begin
        svc_req = rem[2:0];
        tick();
        g = rem & -rem;
        chk_st("R4 grant", 1, 1, 0, g);
        g0 = gcnt; tick(); tick();
        chk("R4 clock during service", gcnt - g0, 2);
        chk("R4 grant held", svc_ack, g);
        svc_done = g[2:0];
        rem = rem & ~g;
        svc_req = rem[2:0];
        tick();
        chk_st("R4 back to gated standby", 0, 1, 0, 0);
      end
      wake_out(1'b0);
    end

    // R9: wake and service request in the same standby cycle
    enter_standby(1'b0);
    irq_wake = 1; svc_req = 3'b010;
    tick();
    chk_st("R9 wake beats service", 1, 0, 1, 0);
    svc_req = '0;
    tick();
    chk_st("R9 run", 1, 0, 0, 0);

    // R8: wake during service is held until done
    enter_standby(1'b0);
    svc_req = 3'b100;
    tick();
    chk_st("R8 service", 1, 1, 0, 4);
    irq_wake = 1;
    tick();
    chk_st("R8 wake held in service", 1, 1, 0, 4);
    svc_done = 3'b100; svc_req = '0;
    tick();
    chk_st("R8 done goes to wake", 1, 0, 1, 0);
    tick();

    // R10: event flag via sev_pulse, then via evt_in
    for (int k = 0; k < 2; k++) begin
      pipe_idle = 1; mem_drained = 1;
      if (k == 0) sev_pulse = 1; else evt_in = 1;
      tick();
      wfe_req = 1;
      tick();
      chk_st("R10 wfe falls through", 1, 0, 0, 0);
      tick();
      chk_st("R10 no drain after consume", 1, 0, 0, 0);
      enter_standby(1'b1);
      chk("R10 flag cleared", in_standby, 1);
      wake_out(1'b1);
    end

    // R11: wake while draining
    pipe_idle = 0; mem_drained = 1; wfi_req = 1;
    tick();
    irq_wake = 1;
    tick();
    chk_st("R11 drain aborted by wake", 1, 0, 1, 0);
    tick();

    // R12: wfe_req while draining for WFI keeps WFI wake rule
    pipe_idle = 0; wfi_req = 1;
    tick();
    wfe_req = 1;
    tick();
    pipe_idle = 1;
    tick();
    chk_st("R12 standby", 0, 1, 0, 0);
    evt_in = 1; wfi_req = 1;
    tick();
    chk_st("R12 requests ignored in standby", 0, 1, 0, 0);
    wake_out(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule